// File: doc/BRIEF.md
# Sliding-Window Serial Parity Generator

This block takes a serial bit stream, one candidate bit per clock qualified by a valid strobe, and keeps a parity bit over the last `WIN_LEN` accepted bits (eight by default). Each accepted bit enters a serial-in parallel-out shift register made of `WIN_LEN` cascaded stages. The whole register is visible as a parallel window, and an XOR reduction of that window feeds a registered parity output. The parity moves by one bit position with every accepted bit, so it always describes a window that slides along the stream. It is never computed once per framed word.

The window register and the parity register load on the same clock edge. In the cycle after a valid bit is taken, `window_o` already holds that bit in stage 0 and `parity_o` already covers that window. A small controller with two states tracks whether the window has been filled since reset. `ST_FILL` is the state after reset, and it counts accepted bits. On the edge that accepts bit number `WIN_LEN`, the controller takes the transition `ST_FILL -> ST_FULL`. `ST_FULL` holds until the next reset, and only reset leads out of it (`ST_FULL -> ST_FILL`). The flag `full_o` is high exactly while the controller is in `ST_FULL`. Parity defaults to even. Setting the parameter `ODD_PARITY` to 1 gives odd parity instead.

Top module: `sliding_parity_gen`

## Requirements
- R1: While `rst_i` is high at a rising edge, the edge clears `window_o` to all zeros and drives `full_o` low. It sets `parity_o` to 0 for even parity, or to 1 when `ODD_PARITY` is 1. Reset takes priority over `valid_i`.
- R2: On a rising edge with `valid_i` high and no reset, the new `window_o` is the old `window_o` shifted up by one position, with `bit_i` in bit 0. Bit 0 is the newest bit, and bit `WIN_LEN-1` is the oldest bit still held.
- R3: On a rising edge with `valid_i` low, `window_o`, `parity_o` and `full_o` keep their values, whatever `bit_i` is.
- R4: With even parity (`ODD_PARITY` = 0), `parity_o` equals the XOR of all bits of `window_o`. It is updated on the same edge that updates the window.
- R5: `parity_o` depends only on the last `WIN_LEN` accepted bits. A bit stops affecting `parity_o` once `WIN_LEN` newer bits have been accepted.
- R6: `full_o` stays low until the edge that accepts the `WIN_LEN`-th valid bit since reset, and it is high right after that edge. Cycles with `valid_i` low do not count.
- R7: Once high, `full_o` stays high until the next reset.
- R8: With `ODD_PARITY` = 1, `parity_o` equals the inverse of the XOR of all bits of `window_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Serial data bit |
| valid_i | input | 1 | High when `bit_i` should be accepted on this edge |
| parity_o | output | 1 | Registered parity of the current window |
| window_o | output | WIN_LEN | Parallel window; bit 0 is the newest bit |
| full_o | output | 1 | High once `WIN_LEN` bits have been accepted since reset |

## Verification
Every result of this block is due one clock after its stimulus. The window, the parity and the fill flag are all registered on the edge that takes a valid bit or sees a reset. There is no extra pipeline stage. The bench drives inputs at the falling edge and samples 1 ns after the next rising edge. At that point it compares all three outputs against a model that was updated for exactly that one edge. For the hold requirement, the bench compares the outputs after the idle edge with their values before it.

// File: rtl/sliding_parity_pkg.sv
package sliding_parity_pkg;

    // Fill controller states
    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_FULL = 1'b1
    } fill_state_t;

    // Parity of a vector with optional inversion for odd parity
    function automatic logic fold_parity(input logic [63:0] vec, input int unsigned len,
                                         input logic invert);
        logic acc;
        acc = invert;
        for (int unsigned i = 0; i < 64; i++) begin
            if (i < len) acc = acc ^ vec[i];
        end
        return acc;
    endfunction

endpackage

// File: rtl/sliding_parity_sipo.sv
module sliding_parity_sipo #(
    parameter int WIN_LEN = 8
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               shift_en_i,
    input  logic               bit_i,
    output logic [WIN_LEN-1:0] next_o,
    output logic [WIN_LEN-1:0] stage_o
);

    logic [WIN_LEN-1:0] stage_q;

    // Next-value network: stage 0 takes the serial bit, stage k takes stage k-1
    assign next_o[0] = bit_i;
    for (genvar k = 1; k < WIN_LEN; k++) begin : g_link
        assign next_o[k] = stage_q[k-1];
    end

    for (genvar k = 0; k < WIN_LEN; k++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                stage_q[k] <= 1'b0;
            end else if (shift_en_i) begin
                stage_q[k] <= next_o[k];
            end
        end
    end

    assign stage_o = stage_q;

endmodule

// File: rtl/sliding_parity_reduce.sv
module sliding_parity_reduce #(
    parameter int WIN_LEN    = 8,
    parameter int ODD_PARITY = 0
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               load_i,
    input  logic [WIN_LEN-1:0] vec_i,
    output logic               parity_o
);

    localparam logic INV_BIT = (ODD_PARITY != 0);

    logic [WIN_LEN-1:0] chain;
    logic               parity_q;

    // Running XOR chain across the window
    assign chain[0] = vec_i[0];
    for (genvar k = 1; k < WIN_LEN; k++) begin : g_xor
        assign chain[k] = chain[k-1] ^ vec_i[k];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            parity_q <= INV_BIT;
        end else if (load_i) begin
            parity_q <= chain[WIN_LEN-1] ^ INV_BIT;
        end
    end

    assign parity_o = parity_q;

endmodule

// File: rtl/sliding_parity_fill.sv
module sliding_parity_fill
    import sliding_parity_pkg::*;
#(
    parameter int WIN_LEN = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic take_i,
    output logic full_o
);

    localparam int CNT_W = $clog2(WIN_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIN_LEN - 1);

    fill_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State and counter register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_FILL: begin
                if (take_i) begin
                    if (cnt_q == LAST_CNT) begin
                        state_d = ST_FULL;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_FULL: begin
                state_d = ST_FULL;
            end
            default: begin
                state_d = ST_FILL;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_FULL: full_o = 1'b1;
            default: full_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sliding_parity_gen.sv
module sliding_parity_gen #(
    parameter int WIN_LEN    = 8,
    parameter int ODD_PARITY = 0
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               bit_i,
    input  logic               valid_i,
    output logic               parity_o,
    output logic [WIN_LEN-1:0] window_o,
    output logic               full_o
);

    logic [WIN_LEN-1:0] win_next;

    sliding_parity_sipo #(.WIN_LEN(WIN_LEN)) u_sipo (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .shift_en_i (valid_i),
        .bit_i      (bit_i),
        .next_o     (win_next),
        .stage_o    (window_o)
    );

    // Parity is loaded from the next window so it aligns with window_o
    sliding_parity_reduce #(.WIN_LEN(WIN_LEN), .ODD_PARITY(ODD_PARITY)) u_reduce (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (valid_i),
        .vec_i    (win_next),
        .parity_o (parity_o)
    );

    sliding_parity_fill #(.WIN_LEN(WIN_LEN)) u_fill (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .take_i (valid_i),
        .full_o (full_o)
    );

endmodule

// File: rtl/sliding_parity_gen_chk.sv
module sliding_parity_gen_chk #(
    parameter int WIN_LEN    = 8,
    parameter int ODD_PARITY = 0
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               bit_i,
    input logic               valid_i,
    input logic               parity_o,
    input logic [WIN_LEN-1:0] window_o,
    input logic               full_o
);

    localparam int   CNT_W   = $clog2(WIN_LEN + 1);
    localparam logic INV_BIT = (ODD_PARITY != 0);

    logic [CNT_W-1:0] seen_q;

    // Independent saturating count of accepted bits
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seen_q <= '0;
        end else if (valid_i && (seen_q != CNT_W'(WIN_LEN))) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (window_o == '0) && !full_o && (parity_o == INV_BIT)); // R1

    AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i |=> window_o == {$past(window_o[WIN_LEN-2:0]), $past(bit_i)}); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |=> $stable(window_o) && $stable(parity_o) && $stable(full_o)); // R3

    AST_PARITY_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        parity_o == ((^window_o) ^ INV_BIT)); // R4 R8

    AST_FULL_TIMING: assert property (@(posedge clk_i) disable iff (rst_i)
        full_o == (seen_q == CNT_W'(WIN_LEN))); // R6

    AST_FULL_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        full_o |=> full_o); // R7

endmodule

bind sliding_parity_gen sliding_parity_gen_chk #(
    .WIN_LEN    (WIN_LEN),
    .ODD_PARITY (ODD_PARITY)
) chk_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .bit_i    (bit_i),
    .valid_i  (valid_i),
    .parity_o (parity_o),
    .window_o (window_o),
    .full_o   (full_o)
);

// File: tb/sliding_parity_gen_tb.sv
`timescale 1ns/1ps
module sliding_parity_gen_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         bit_in;
    logic         valid;
    logic         par_even, par_odd;
    logic [W-1:0] win_even, win_odd;
    logic         full_even, full_odd;

    int checks = 0;
    int fails  = 0;
    logic         done = 1'b0;

    // Bench model
    logic [W-1:0] m_win;
    int           m_cnt;

    always #5 clk = ~clk;

    sliding_parity_gen #(.WIN_LEN(W), .ODD_PARITY(0)) dut_i (
        .clk_i(clk), .rst_i(rst), .bit_i(bit_in), .valid_i(valid),
        .parity_o(par_even), .window_o(win_even), .full_o(full_even)
    );

    sliding_parity_gen #(.WIN_LEN(W), .ODD_PARITY(1)) dut_odd_i (
        .clk_i(clk), .rst_i(rst), .bit_i(bit_in), .valid_i(valid),
        .parity_o(par_odd), .window_o(win_odd), .full_o(full_odd)
    );

    function automatic logic exp_parity(input logic [W-1:0] v, input logic odd);
        return (^v) ^ odd;
    endfunction

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(win_even, m_win, {req, " window"});
        check(W'(par_even), W'(exp_parity(m_win, 1'b0)), "R4 even parity");
        check(W'(par_odd), W'(exp_parity(m_win, 1'b1)), "R8 odd parity");
        check(W'(full_even), W'(m_cnt >= W), "R6 full flag");
        check(win_odd, m_win, {req, " odd-instance window"});
    endtask

    // One clock: drive at falling edge, sample 1 ns after the rising edge
    task automatic step(input logic r, input logic v, input logic b);
        @(negedge clk);
        rst = r; valid = v; bit_in = b;
        @(posedge clk);
        #1;
        if (r) begin
            m_win = '0;
            m_cnt = 0;
        end else if (v) begin
            m_win = {m_win[W-2:0], b};
            if (m_cnt < W) m_cnt++;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [W-1:0] snap_w;
        logic         snap_p;
        logic         snap_f;
        void'($urandom(32'd20240611));
        rst = 1'b1; valid = 1'b0; bit_in = 1'b0;
        m_win = '0; m_cnt = 0;

        // R1: reset state, reset wins over valid
        step(1'b1, 1'b1, 1'b1);
        check_all("R1");
        check(W'(par_odd), W'(1), "R1 odd reset parity");
        check(W'(full_even), W'(0), "R1 full after reset");

        // R6: seven bits with idle gaps keep full low, the eighth raises it
        for (int i = 0; i < W - 1; i++) begin
            step(1'b0, 1'b1, 1'(i % 2));
            step(1'b0, 1'b0, 1'b1);
            check(W'(full_even), W'(0), "R6 not yet full");
        end
        step(1'b0, 1'b1, 1'b1);
        check(W'(full_even), W'(1), "R6 full on eighth bit");
        check_all("R2");

        // R3: idle cycles with toggling data hold everything
        snap_w = win_even; snap_p = par_even; snap_f = full_even;
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b0, 1'(i[0]));
            check(win_even, snap_w, "R3 window hold");
            check(W'(par_even), W'(snap_p), "R3 parity hold");
            check(W'(full_even), W'(snap_f), "R3 full hold");
        end

        // R5: a single one ages out after W newer zeros
        step(1'b0, 1'b1, 1'b1);
        for (int i = 0; i < W; i++) begin
            step(1'b0, 1'b1, 1'b0);
            check_all("R5");
        end
        check(W'(par_even), W'(0), "R5 old bit aged out");
        check(win_even, '0, "R5 window cleared by shifting");

        // R7: full stays up through long traffic
        for (int i = 0; i < 20; i++) begin
            step(1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            check(W'(full_even), W'(1), "R7 full sticky");
        end

        // Random traffic with occasional resets
        for (int i = 0; i < 4000; i++) begin
            logic r, v, b;
            r = ($urandom_range(0, 199) == 0);
            v = ($urandom_range(0, 9) < 7);
            b = 1'($urandom_range(0, 1));
            step(r, v, b);
            check_all(r ? "R1" : (v ? "R2" : "R3"));
        end

        done = 1'b1;
        summary();
    end

endmodule